// File: doc/BRIEF.md
# Byte-Lane Data Memory Access Unit

This block connects a 16-bit processor datapath to an on-chip data RAM built as two parallel 8-bit lanes that share one word index but have their own write enables. A request carries a 16-bit byte address, a flag that selects a byte or a word transfer, a write flag and write data. The unit decides which lanes take part, places the selected byte on the low 8 bits for byte reads, and catches word transfers at odd addresses. It keeps writes that are misaligned or outside the RAM away from the memory. Addresses in the lower half but above the implemented RAM read as zero. Addresses with the top bit set belong to a separate window and are flagged without touching the RAM.

The request side follows valid/ready rules. A request moves on any rising edge where `req_valid` and `req_ready` are both high. `req_ready` is held high at all times, so the unit never applies back-pressure. Every accepted request gives exactly one response, one cycle later, marked by `rsp_valid`. The response side has no ready input, so the consumer must take each response in the cycle it appears. The next byte address for post-increment addressing is produced combinationally in the same cycle as the request.

Top module: `dmem_access_unit`

## Requirements
- R1: A byte read at an even address returns the low lane of the word at that index on `rsp_rdata[7:0]`, and `rsp_rdata[15:8]` is zero.
- R2: A byte read at an odd address returns the high lane of the word on `rsp_rdata[7:0]`, and `rsp_rdata[15:8]` is zero.
- R3: A byte write changes only the lane picked by address bit 0 (0 selects the low lane, 1 selects the high lane), using `req_wdata[7:0]`. The other lane of that word keeps its value.
- R4: A word write at an even address stores `req_wdata[7:0]` in the low lane (byte at the even address) and `req_wdata[15:8]` in the high lane (byte at the odd address). A word read returns {high lane, low lane}.
- R5: A word request with address bit 0 set raises `rsp_trap` in its response cycle. Byte requests and even-address word requests never raise it. This applies whatever the address range.
- R6: A misaligned word write changes no RAM byte.
- R7: A misaligned word read still completes and returns the word stored at the address with bit 0 cleared.
- R8: An address with bit 15 clear and a value of 0x2000 or above reads as zero. A write to such an address changes nothing and raises no trap of its own.
- R9: An address with bit 15 set raises `rsp_window` in its response cycle, reads as zero and never writes the RAM.
- R10: `addr_next` equals `req_addr` + 1 for a byte request and + 2 for a word request, modulo 2^16, in the same cycle.
- R11: `req_ready` is always 1. `rsp_valid` is high exactly in the cycle after each accepted request. A write response carries `rsp_rdata` equal to zero.
- R12: During reset and before the first request, `rsp_valid`, `rsp_trap` and `rsp_window` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the response stage |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (constant 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data. Byte writes use bits 7:0 |
| addr_next | output | 16 | Post-incremented byte address |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 16 | Read data, low-aligned for bytes |
| rsp_trap | output | 1 | Misaligned word access |
| rsp_window | output | 1 | Access fell into the upper-half window |

## Verification
`addr_next` and `req_ready` depend only on the current request, so they are due in the request's own cycle. `rsp_valid`, `rsp_rdata`, `rsp_trap` and `rsp_window` are due one rising edge later, because the RAM read and the flag registers each add one stage. The bench drives each request on a falling edge and checks the combinational outputs 1 ns later. At the next falling edge it compares the registered outputs with the values its model queued for that request. Lane isolation and write suppression are observed through later reads of the same word.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = LANE_W * LANES;

  typedef struct packed {
    logic rd;
    logic byte_op;
    logic hi_sel;
    logic in_ram;
    logic trap;
    logic window;
  } rsp_info_t;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BYTES = 8192,
  parameter int unsigned IDX_W     = 12
) (
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic                          req_word,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic [LANES-1:0]              lane_we,
  output logic [LANES-1:0][LANE_W-1:0]  lane_wdata,
  output logic                          rd_en,
  output logic [IDX_W-1:0]              word_idx,
  output rsp_info_t                     info,
  output logic [ADDR_W-1:0]             addr_next
);
  logic window, in_ram, misalign, wr_ok;

  assign window   = req_addr[ADDR_W-1];
  assign in_ram   = !window && (32'(req_addr) < RAM_BYTES);
  assign misalign = req_word && req_addr[0];
  assign word_idx = req_addr[IDX_W:1];
  assign wr_ok    = req_valid && req_write && in_ram && !misalign;
  assign rd_en    = req_valid && !req_write && in_ram;

  assign lane_we[0]    = wr_ok && (req_word || !req_addr[0]);
  assign lane_we[1]    = wr_ok && (req_word ||  req_addr[0]);
  assign lane_wdata[0] = req_wdata[LANE_W-1:0];
  assign lane_wdata[1] = req_word ? req_wdata[DATA_W-1:LANE_W] : req_wdata[LANE_W-1:0];

  assign addr_next = req_addr + (req_word ? ADDR_W'(2) : ADDR_W'(1));

  always_comb begin
    info.rd      = !req_write;
    info.byte_op = !req_word;
    info.hi_sel  = req_addr[0];
    info.in_ram  = in_ram;
    info.trap    = misalign;
    info.window  = window;
  end
endmodule

// File: rtl/dmem_lane_ram.sv
module dmem_lane_ram #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned IDX_W  = 12,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/dmem_rsp_stage.sv
module dmem_rsp_stage
  import dmem_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  rsp_info_t                     info,
  input  logic [LANES-1:0][LANE_W-1:0]  lane_rdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic                          rsp_trap,
  output logic                          rsp_window
);
  logic      valid_q;
  rsp_info_t info_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      info_q  <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) info_q <= info;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (valid_q && info_q.rd && info_q.in_ram) begin
      if (info_q.byte_op)
        rsp_rdata = {{LANE_W{1'b0}}, info_q.hi_sel ? lane_rdata[1] : lane_rdata[0]};
      else
        rsp_rdata = {lane_rdata[1], lane_rdata[0]};
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_trap   = valid_q && info_q.trap;
  assign rsp_window = valid_q && info_q.window;
endmodule

// File: rtl/dmem_access_unit.sv
module dmem_access_unit
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BYTES = 8192,
  localparam int unsigned WORDS    = RAM_BYTES / LANES,
  localparam int unsigned IDX_W    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] addr_next,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_trap,
  output logic              rsp_window
);
  logic [LANES-1:0]             lane_we;
  logic [LANES-1:0][LANE_W-1:0] lane_wdata;
  logic [LANES-1:0][LANE_W-1:0] lane_rdata;
  logic                         rd_en;
  logic [IDX_W-1:0]             word_idx;
  rsp_info_t                    info;

  assign req_ready = 1'b1;

  dmem_decode #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .IDX_W(IDX_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .lane_we(lane_we),
    .lane_wdata(lane_wdata), .rd_en(rd_en), .word_idx(word_idx),
    .info(info), .addr_next(addr_next)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dmem_lane_ram #(.LANE_W(LANE_W), .IDX_W(IDX_W)) u_ram (
      .clk(clk), .we(lane_we[g]), .re(rd_en), .idx(word_idx),
      .wdata(lane_wdata[g]), .rdata(lane_rdata[g])
    );
  end

  dmem_rsp_stage u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .info(info),
    .lane_rdata(lane_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_trap(rsp_trap), .rsp_window(rsp_window)
  );

  p_trap_odd_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word && req_addr[0]) |=> rsp_trap);
  p_no_trap_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_word && req_addr[0])) |=> !rsp_trap);
  p_misalign_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word && req_addr[0]) |-> (lane_we == '0));
  p_byte_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_word) |=> (rsp_rdata[DATA_W-1:LANE_W] == '0));
  p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr[ADDR_W-1] && (32'(req_addr) >= RAM_BYTES)) |=> (rsp_rdata == '0));
  p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1]) |=> (rsp_window && rsp_rdata == '0));
  p_window_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[ADDR_W-1]) |-> (lane_we == '0));
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/sim_dmem_access_unit.sv
module sim_dmem_access_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_trap, rsp_window;
  logic [15:0] addr_next, rsp_rdata;

  always #5 clk = ~clk;

  dmem_access_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .addr_next(addr_next), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap), .rsp_window(rsp_window)
  );

  int checks = 0, errors = 0;
  logic [7:0] ref_mem [int];
  bit pend = 0;
  logic p_valid, p_trap, p_win;
  logic [15:0] p_rdata;
  string p_tag;

  task automatic chk(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_prev();
    if (pend) begin
      chk(rsp_valid === p_valid, "R11", "rsp_valid", 16'(rsp_valid), 16'(p_valid));
      if (p_valid) begin
        chk(rsp_rdata === p_rdata, p_tag, "rsp_rdata", rsp_rdata, p_rdata);
        chk(rsp_trap === p_trap, "R5", "rsp_trap", 16'(rsp_trap), 16'(p_trap));
        chk(rsp_window === p_win, "R9", "rsp_window", 16'(rsp_window), 16'(p_win));
      end
    end
  endtask

  task automatic step(bit v, bit w, bit wd, logic [15:0] a, logic [15:0] d, string tag);
    bit in_ram, trap;
    logic [15:0] e, exp_rd;
    string t;
    compare_prev();
    req_valid = v; req_write = w; req_word = wd; req_addr = a; req_wdata = d;
    #1;
    chk(req_ready === 1'b1, "R11", "req_ready", 16'(req_ready), 16'd1);
    if (v) chk(addr_next === a + (wd ? 16'd2 : 16'd1), "R10", "addr_next",
               addr_next, a + (wd ? 16'd2 : 16'd1));
    in_ram = !a[15] && (a < 16'h2000);
    trap   = wd && a[0];
    e      = a & 16'hFFFE;
    exp_rd = '0;
    if (a[15])          t = "R9";
    else if (!in_ram)   t = "R8";
    else if (w)         t = "R11";
    else if (trap)      t = "R7";
    else if (wd)        t = "R4";
    else if (a[0])      t = "R2";
    else                t = "R1";
    if (v && !w && in_ram)
      exp_rd = wd ? {ref_mem[int'(e) + 1], ref_mem[int'(e)]}
                  : {8'h00, ref_mem[int'(a)]};
    if (v && w && in_ram && !trap) begin
      if (wd) begin
        ref_mem[int'(e)]     = d[7:0];
        ref_mem[int'(e) + 1] = d[15:8];
      end else ref_mem[int'(a)] = d[7:0];
    end
    pend = 1; p_valid = v; p_rdata = exp_rd; p_trap = trap;
    p_win = a[15]; p_tag = (tag != "") ? tag : t;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [15:0] pick_addr();
    int r = int'($urandom_range(0, 9));
    if (r < 4)      return 16'($urandom_range(0, 63));
    else if (r < 7) return 16'h1FC0 + 16'($urandom_range(0, 63));
    else if (r < 8) return 16'($urandom_range(16'h2000, 16'h7FFF));
    else            return 16'h8000 | 16'($urandom_range(0, 32767));
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R12: outputs quiet during reset
    chk(rsp_valid === 1'b0, "R12", "rsp_valid in reset", 16'(rsp_valid), 0);
    chk(rsp_trap === 1'b0, "R12", "rsp_trap in reset", 16'(rsp_trap), 0);
    chk(rsp_window === 1'b0, "R12", "rsp_window in reset", 16'(rsp_window), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R12", "rsp_valid after reset", 16'(rsp_valid), 0);
    // fill two regions with word writes (R4)
    for (int i = 0; i < 64; i += 2) step(1, 1, 1, 16'(i), 16'($urandom), "");
    for (int i = 16'h1FC0; i < 16'h2000; i += 2) step(1, 1, 1, 16'(i), 16'($urandom), "");
    // R3: byte writes touch one lane only
    step(1, 1, 0, 16'h0005, 16'h77A5, "");
    step(1, 0, 1, 16'h0004, 16'h0000, "R3");
    step(1, 1, 0, 16'h0006, 16'h993C, "");
    step(1, 0, 1, 16'h0006, 16'h0000, "R3");
    // R1 / R2: byte reads
    step(1, 0, 0, 16'h0004, 16'h0000, "R1");
    step(1, 0, 0, 16'h0005, 16'h0000, "R2");
    // R6: misaligned write leaves both neighbouring words intact
    step(1, 1, 1, 16'h0009, 16'hDEAD, "");
    step(1, 0, 1, 16'h0008, 16'h0000, "R6");
    step(1, 0, 1, 16'h000A, 16'h0000, "R6");
    // R7: misaligned read returns aligned word
    step(1, 0, 1, 16'h000B, 16'h0000, "R7");
    // R8: unimplemented range
    step(1, 1, 1, 16'h2000, 16'h1234, "R8");
    step(1, 0, 1, 16'h2000, 16'h0000, "R8");
    step(1, 0, 0, 16'h7FFF, 16'h0000, "R8");
    // R9: window write must not alias into RAM index 0
    step(1, 1, 1, 16'h8000, 16'hBEEF, "R9");
    step(1, 0, 1, 16'h0000, 16'h0000, "R9");
    step(1, 0, 1, 16'h8000, 16'h0000, "R9");
    // R10: wrap of post-increment
    step(1, 0, 0, 16'hFFFF, 16'h0000, "");
    step(1, 0, 1, 16'hFFFE, 16'h0000, "");
    // R11: idle cycles give no response
    step(0, 0, 0, 16'h0000, 16'h0000, "");
    step(0, 0, 0, 16'h0000, 16'h0000, "");
    for (int n = 0; n < 3000; n++)
      step(($urandom_range(0, 9) != 0), 1'($urandom), 1'($urandom), pick_addr(),
           16'($urandom), "");
    step(0, 0, 0, 16'h0000, 16'h0000, "");
    compare_prev();
    finish_run();
  end
endmodule